// File: doc/BRIEF.md
# Two-Port Lock Memory with Atomic Test-and-Set

This block is a small synchronous memory that two independent requesters reach through two identical ports. Both ports can address every word. Each port can issue a plain read, a plain write, or an atomic test-and-set. A test-and-set returns the word's old value. It stores the requester's data only when that old value is zero, so a zero word means a free lock. Software takes a lock by test-and-set and releases it with an ordinary write of zero.

A test-and-set occupies its port for two cycles. In the first cycle the port reads the word and records the address in its own reservation register. In the second cycle it writes conditionally and clears the reservation. A test-and-set from the other port that hits a held reservation, or that arrives in the same cycle for the same address, is not queued. The block refuses it with a one-cycle busy pulse, and the requester tries again later. Plain accesses never look at reservations.

Top module: `tas_dpram`

## Requirements
- R1: After reset every word reads 0, and the done and busy outputs of both ports are low.
- R2: Operation codes are 0 idle, 1 read, 2 write, 3 test-and-set. A read sampled at a clock edge puts the addressed word on rdata, with done high, after that same edge.
- R3: A write sampled at an edge stores wdata and pulses done after that edge. If both ports write the same address at the same edge, the port 0 data is kept.
- R4: A test-and-set sampled at edge N raises neither done nor busy after edge N. After edge N+1, done is high and rdata holds the old word.
- R5: A test-and-set stores its wdata only if the old word is 0. Otherwise the word is unchanged.
- R6: A test-and-set whose address matches the other port's held reservation produces busy for exactly one cycle after its sampling edge. It produces no done and changes no memory.
- R7: If both ports issue a test-and-set to one address at the same edge, port 0 proceeds and port 1 gets busy.
- R8: Once the reserving operation completes, a retried test-and-set from the other port is accepted and returns the word that the first operation left.
- R9: Test-and-set operations to different addresses on the two ports at the same edge both complete, with no busy.
- R10: Plain reads and writes from the other port during a reservation are never refused. A read sees the word as it was before the write-back. A plain write at the same edge as the write-back to that address is overwritten by the write-back.
- R11: An ordinary write of 0 releases a lock, so the next test-and-set on that word succeeds.
- R12: A request that a port presents during its own test-and-set's second cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| p0_op | input | 2 | Port 0 operation code |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write / set data |
| p0_rdata | output | DATA_W | Port 0 read or old data |
| p0_done | output | 1 | Port 0 operation completed |
| p0_busy | output | 1 | Port 0 test-and-set refused |
| p1_op | input | 2 | Port 1 operation code |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write / set data |
| p1_rdata | output | DATA_W | Port 1 read or old data |
| p1_done | output | 1 | Port 1 operation completed |
| p1_busy | output | 1 | Port 1 test-and-set refused |

## Verification
Two functions can land on the same edge. One case is two test-and-sets competing for one word, which resolves to port 0 proceeding and port 1 being refused. The other is a test-and-set write-back meeting a plain write or read from the opposite port. The bench provokes both by driving the two ports at the same negative edge, either with identical addresses or with the plain access placed in the reserving port's second cycle. It judges the result from busy and done, from the returned old value, and from a later read-back of the contested word.

// File: rtl/tas_dpram_pkg.sv
package tas_dpram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_TAS   = 2'd3
   } op_e;

endpackage

// File: rtl/tas_dpram_mem.sv
module tas_dpram_mem #(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  pw_en,
   input  logic [1:0][ADDR_W-1:0]      pw_addr,
   input  logic [1:0][DATA_W-1:0]      pw_data,
   input  logic [1:0]                  wb_en,
   input  logic [1:0][ADDR_W-1:0]      wb_addr,
   input  logic [1:0][DATA_W-1:0]      wb_data,
   input  logic [1:0][ADDR_W-1:0]      rd_addr,
   output logic [1:0][DATA_W-1:0]      rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   // Later statements win: plain writes first (port 1, then port 0),
   // then test-and-set write-backs (port 1, then port 0).
   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) store[i] <= '0;
            end else begin
               for (int p = 1; p >= 0; p--)
                  if (pw_en[p]) store[pw_addr[p]] <= pw_data[p];
               for (int p = 1; p >= 0; p--)
                  if (wb_en[p]) store[wb_addr[p]] <= wb_data[p];
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            for (int p = 1; p >= 0; p--)
               if (pw_en[p]) store[pw_addr[p]] <= pw_data[p];
            for (int p = 1; p >= 0; p--)
               if (wb_en[p]) store[wb_addr[p]] <= wb_data[p];
         end
      end
   endgenerate

   for (genvar p = 0; p < 2; p++) begin : g_rd
      assign rd_data[p] = store[rd_addr[p]];
   end

   // R3: same-address plain writes keep port 0 data
   p_p0_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_en[0] && pw_en[1] && pw_addr[0] == pw_addr[1]
       && !(wb_en[0] && wb_addr[0] == pw_addr[0])
       && !(wb_en[1] && wb_addr[1] == pw_addr[0]))
      |=> store[$past(pw_addr[0])] == $past(pw_data[0]));

endmodule

// File: rtl/tas_dpram_conflict.sv
module tas_dpram_conflict #(
   parameter int ADDR_W = 4
) (
   input  logic [1:0]             tas_req,
   input  logic [1:0][ADDR_W-1:0] req_addr,
   input  logic [1:0]             res_valid,
   input  logic [1:0][ADDR_W-1:0] res_addr,
   output logic [1:0]             refuse
);
   logic hit0_held, hit1_held, same_new;

   assign hit0_held = res_valid[1] && (res_addr[1] == req_addr[0]);
   assign hit1_held = res_valid[0] && (res_addr[0] == req_addr[1]);
   assign same_new  = tas_req[0] && !hit0_held && (req_addr[0] == req_addr[1]);

   // Port 0 takes priority for a same-edge collision.
   assign refuse[0] = tas_req[0] && hit0_held;
   assign refuse[1] = tas_req[1] && (hit1_held || same_new);

endmodule

// File: rtl/tas_dpram_port.sv
module tas_dpram_port
   import tas_dpram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              refuse_i,
   output logic              tas_req_o,
   output logic              pw_en_o,
   output logic              wb_en_o,
   output logic [ADDR_W-1:0] wb_addr_o,
   output logic [DATA_W-1:0] wb_data_o,
   output logic              res_valid_o,
   output logic [ADDR_W-1:0] res_addr_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              busy_o
);
   logic              res_valid;
   logic [ADDR_W-1:0] res_addr;
   logic [DATA_W-1:0] res_data;
   logic [DATA_W-1:0] old_q;
   logic              accept, tas_go;

   // A port takes no new request during its own second cycle.
   assign accept    = !res_valid;
   assign tas_req_o = accept && (op_i == OP_TAS);
   assign tas_go    = tas_req_o && !refuse_i;
   assign pw_en_o   = accept && (op_i == OP_WRITE);

   assign wb_en_o     = res_valid && (old_q == '0);
   assign wb_addr_o   = res_addr;
   assign wb_data_o   = res_data;
   assign res_valid_o = res_valid;
   assign res_addr_o  = res_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_data  <= '0;
         old_q     <= '0;
         rdata_o   <= '0;
         done_o    <= 1'b0;
         busy_o    <= 1'b0;
      end else begin
         res_valid <= tas_go;
         busy_o    <= tas_req_o && refuse_i;
         done_o    <= res_valid || (accept && (op_i == OP_READ || op_i == OP_WRITE));
         if (tas_go) begin
            res_addr <= addr_i;
            res_data <= wdata_i;
            old_q    <= word_i;
         end
         if (res_valid)
            rdata_o <= old_q;
         else if (op_i == OP_READ)
            rdata_o <= word_i;
      end
   end

   // R4: the reservation window is exactly one cycle
   p_res_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R4: a held reservation always finishes with done
   p_done_after_tas_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> done_o);

   // R6: a refused request never reports completion
   p_busy_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);

endmodule

// File: rtl/tas_dpram.sv
module tas_dpram
   import tas_dpram_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        p0_op,
   input  logic [ADDR_W-1:0] p0_addr,
   input  logic [DATA_W-1:0] p0_wdata,
   output logic [DATA_W-1:0] p0_rdata,
   output logic              p0_done,
   output logic              p0_busy,
   input  logic [1:0]        p1_op,
   input  logic [ADDR_W-1:0] p1_addr,
   input  logic [DATA_W-1:0] p1_wdata,
   output logic [DATA_W-1:0] p1_rdata,
   output logic              p1_done,
   output logic              p1_busy
);
   localparam int NPORT = 2;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("tas_dpram: ADDR_W must lie in 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("tas_dpram: DATA_W must be at least 1");
   end

   logic [NPORT-1:0][1:0]        op_a;
   logic [NPORT-1:0][ADDR_W-1:0] addr_a, wb_addr_a, res_addr_a;
   logic [NPORT-1:0][DATA_W-1:0] wdata_a, word_a, wb_data_a, rdata_a;
   logic [NPORT-1:0]             tas_req_a, refuse_a, pw_en_a, wb_en_a;
   logic [NPORT-1:0]             res_valid_a, done_a, busy_a;

   assign op_a[0]    = p0_op;
   assign op_a[1]    = p1_op;
   assign addr_a[0]  = p0_addr;
   assign addr_a[1]  = p1_addr;
   assign wdata_a[0] = p0_wdata;
   assign wdata_a[1] = p1_wdata;
   assign p0_rdata   = rdata_a[0];
   assign p1_rdata   = rdata_a[1];
   assign p0_done    = done_a[0];
   assign p1_done    = done_a[1];
   assign p0_busy    = busy_a[0];
   assign p1_busy    = busy_a[1];

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      tas_dpram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
         .clk         (clk),
         .rst_n       (rst_n),
         .op_i        (op_e'(op_a[p])),
         .addr_i      (addr_a[p]),
         .wdata_i     (wdata_a[p]),
         .word_i      (word_a[p]),
         .refuse_i    (refuse_a[p]),
         .tas_req_o   (tas_req_a[p]),
         .pw_en_o     (pw_en_a[p]),
         .wb_en_o     (wb_en_a[p]),
         .wb_addr_o   (wb_addr_a[p]),
         .wb_data_o   (wb_data_a[p]),
         .res_valid_o (res_valid_a[p]),
         .res_addr_o  (res_addr_a[p]),
         .rdata_o     (rdata_a[p]),
         .done_o      (done_a[p]),
         .busy_o      (busy_a[p])
      );
   end

   tas_dpram_conflict #(.ADDR_W(ADDR_W)) u_conflict (
      .tas_req   (tas_req_a),
      .req_addr  (addr_a),
      .res_valid (res_valid_a),
      .res_addr  (res_addr_a),
      .refuse    (refuse_a)
   );

   tas_dpram_mem #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .pw_en   (pw_en_a),
      .pw_addr (addr_a),
      .pw_data (wdata_a),
      .wb_en   (wb_en_a),
      .wb_addr (wb_addr_a),
      .wb_data (wb_data_a),
      .rd_addr (addr_a),
      .rd_data (word_a)
   );

   // R7: the two ports never hold a reservation on one word together
   p_no_shared_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid_a[0] && res_valid_a[1] && res_addr_a[0] == res_addr_a[1]));

endmodule

// File: tb/tas_dpram_test.sv
`timescale 1ns/1ps
module tas_dpram_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op [2];
   logic [3:0]  ad [2];
   logic [15:0] wd [2];
   logic [15:0] rd [2];
   logic        dn [2];
   logic        bz [2];
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tas_dpram #(.ADDR_W(4), .DATA_W(16)) uut (
      .clk(clk), .rst_n(rst_n),
      .p0_op(op[0]), .p0_addr(ad[0]), .p0_wdata(wd[0]),
      .p0_rdata(rd[0]), .p0_done(dn[0]), .p0_busy(bz[0]),
      .p1_op(op[1]), .p1_addr(ad[1]), .p1_wdata(wd[1]),
      .p1_rdata(rd[1]), .p1_done(dn[1]), .p1_busy(bz[1])
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic drv(input int p, input logic [1:0] o, input logic [3:0] a, input logic [15:0] d);
      op[p] = o; ad[p] = a; wd[p] = d;
   endtask

   task automatic idle();
      op[0] = 2'd0; op[1] = 2'd0;
   endtask

   task automatic rd_chk(input int p, input logic [3:0] a, input logic [15:0] exp, input string tag);
      drv(p, 2'd1, a, '0);
      step();
      chk(tag, rd[p], exp);
      chk(tag, dn[p], 1'b1);
      idle();
      step();
   endtask

   task automatic wr(input int p, input logic [3:0] a, input logic [15:0] d);
      drv(p, 2'd2, a, d);
      step();
      chk("R3 write done", dn[p], 1'b1);
      idle();
      step();
   endtask

   task automatic t_reset();
      chk("R1 p0 done", dn[0], 1'b0);
      chk("R1 p1 done", dn[1], 1'b0);
      chk("R1 p0 busy", bz[0], 1'b0);
      chk("R1 p1 busy", bz[1], 1'b0);
      for (int a = 0; a < 16; a++) rd_chk(a % 2, 4'(a), 16'h0, "R1 cleared word");
   endtask

   task automatic t_plain();
      wr(0, 4'd3, 16'h1234);
      rd_chk(1, 4'd3, 16'h1234, "R2 read other port");
      drv(0, 2'd2, 4'd5, 16'hAAAA);
      drv(1, 2'd2, 4'd5, 16'h5555);
      step();
      chk("R3 both done p0", dn[0], 1'b1);
      chk("R3 both done p1", dn[1], 1'b1);
      idle();
      step();
      rd_chk(1, 4'd5, 16'hAAAA, "R3 port0 kept");
   endtask

   task automatic t_tas_basic();
      drv(0, 2'd3, 4'd7, 16'h0001);
      step();
      chk("R4 no done first cycle", dn[0], 1'b0);
      chk("R4 no busy first cycle", bz[0], 1'b0);
      idle();
      step();
      chk("R4 done second cycle", dn[0], 1'b1);
      chk("R4 old value", rd[0], 16'h0);
      step();
      rd_chk(0, 4'd7, 16'h0001, "R5 set when free");
      drv(1, 2'd3, 4'd7, 16'h0002);
      step();
      idle();
      step();
      chk("R5 taken old value", rd[1], 16'h0001);
      step();
      rd_chk(1, 4'd7, 16'h0001, "R5 taken unchanged");
   endtask

   task automatic t_contend();
      drv(0, 2'd3, 4'd9, 16'h0011);
      step();
      idle();
      drv(1, 2'd3, 4'd9, 16'h0022);
      step();
      chk("R6 busy on contention", bz[1], 1'b1);
      chk("R6 no done when refused", dn[1], 1'b0);
      chk("R6 holder completes", dn[0], 1'b1);
      chk("R6 holder old value", rd[0], 16'h0);
      drv(1, 2'd3, 4'd9, 16'h0022);
      step();
      chk("R6 busy one cycle", bz[1], 1'b0);
      idle();
      step();
      chk("R8 retry done", dn[1], 1'b1);
      chk("R8 retry sees holder word", rd[1], 16'h0011);
      step();
      rd_chk(0, 4'd9, 16'h0011, "R6 refused data not stored");
   endtask

   task automatic t_same_cycle();
      drv(0, 2'd3, 4'd10, 16'h00A0);
      drv(1, 2'd3, 4'd10, 16'h00B0);
      step();
      chk("R7 port1 busy", bz[1], 1'b1);
      chk("R7 port0 not busy", bz[0], 1'b0);
      idle();
      step();
      chk("R7 port0 done", dn[0], 1'b1);
      chk("R7 port1 no done", dn[1], 1'b0);
      step();
      rd_chk(1, 4'd10, 16'h00A0, "R7 port0 value stored");
   endtask

   task automatic t_parallel();
      drv(0, 2'd3, 4'd11, 16'h0003);
      drv(1, 2'd3, 4'd12, 16'h0004);
      step();
      chk("R9 p0 no busy", bz[0], 1'b0);
      chk("R9 p1 no busy", bz[1], 1'b0);
      idle();
      step();
      chk("R9 p0 done", dn[0], 1'b1);
      chk("R9 p1 done", dn[1], 1'b1);
      step();
      rd_chk(0, 4'd11, 16'h0003, "R9 word 11");
      rd_chk(0, 4'd12, 16'h0004, "R9 word 12");
   endtask

   task automatic t_plain_during();
      drv(0, 2'd3, 4'd13, 16'h0077);
      step();
      idle();
      drv(1, 2'd1, 4'd13, '0);
      step();
      chk("R10 read done", dn[1], 1'b1);
      chk("R10 read not busy", bz[1], 1'b0);
      chk("R10 read pre-writeback", rd[1], 16'h0);
      idle();
      step();
      drv(0, 2'd3, 4'd14, 16'h0055);
      step();
      idle();
      drv(1, 2'd2, 4'd14, 16'h0099);
      step();
      chk("R10 write done", dn[1], 1'b1);
      chk("R10 write not busy", bz[1], 1'b0);
      idle();
      step();
      rd_chk(1, 4'd14, 16'h0055, "R10 writeback wins");
   endtask

   task automatic t_release();
      wr(1, 4'd7, 16'h0000);
      drv(1, 2'd3, 4'd7, 16'h0008);
      step();
      idle();
      step();
      chk("R11 old after release", rd[1], 16'h0);
      step();
      rd_chk(0, 4'd7, 16'h0008, "R11 relocked");
   endtask

   task automatic t_own_ignore();
      drv(0, 2'd3, 4'd15, 16'h0006);
      step();
      drv(0, 2'd2, 4'd15, 16'hFFFF);
      step();
      chk("R12 done is tas", dn[0], 1'b1);
      chk("R12 rdata is old", rd[0], 16'h0);
      chk("R12 no busy", bz[0], 1'b0);
      idle();
      step();
      rd_chk(0, 4'd15, 16'h0006, "R12 write ignored");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle();
      for (int p = 0; p < 2; p++) begin ad[p] = '0; wd[p] = '0; end
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_plain();
      t_tas_basic();
      t_contend();
      t_same_cycle();
      t_parallel();
      t_plain_during();
      t_release();
      t_own_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule